// File: doc/BRIEF.md
# System Control Register Block

This block is a word-oriented register file that sits in a 4 KiB bus window and gives software a place to keep plain 32-bit control words. It has a write port and a read port that may both be used in the same clock. Each byte address is turned into a word index by dropping its two low bits. Only the first 512 words have storage. The one exception is a dedicated command word high in the window, which has its own register.

A few locations have side effects. Writing the command word with a reset code (1 or 2) produces a one-clock reset-request pulse. Writing it with the shutdown code (3) produces a one-clock shutdown-request pulse. Any other value is stored and raises nothing. Three status words always read back with bits 29 and 28 set, whatever was written to them. Four identification words come out of reset holding fixed nonzero values, and every other word clears to zero.

Reads are registered. The data appears one clock after the read strobe and stays unchanged until the next strobe.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, word index 0x40 holds 0x05F20121, index 0x41 holds 0x00000002, index 0x42 holds 0x05F30121 and index 0x43 holds 0x05F40121. All other words, the command word and `rd_data` are zero.
- R2: A write stores `wr_data` at word index `wr_addr[11:2]`. A read strobe at `rd_addr` presents that word on `rd_data` in the following cycle.
- R3: A read and a write to the same index in the same cycle return the value held before the write. The new value is seen by later reads.
- R4: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000. The forcing never changes the stored value, so other bits read back as written.
- R5: A write of 1 or 2 to byte offset 0xF00 makes `rst_req` high for exactly the one cycle after the write, with `shut_req` low.
- R6: A write of 3 to byte offset 0xF00 makes `shut_req` high for exactly the one cycle after the write, with `rst_req` low.
- R7: A write of any other value to 0xF00, and any write to another offset, leaves both `rst_req` and `shut_req` low.
- R8: The word at byte offset 0xF00 is stored like an ordinary register and reads back as the last value written there.
- R9: A write whose word index is 0x200 or more, other than the command word, changes no storage. A read at such an index returns zero.
- R10: `rd_data` keeps its value in any cycle that follows a cycle without a read strobe.
- R11: Address bits 1:0 are ignored on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte address within the window |
| wr_data | input | 32 | Write data, always a full word |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte address within the window |
| rd_data | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |
| shut_req | output | 1 | One-cycle shutdown request |

## Verification
The assertions assume that reset is held for at least two clocks. They also assume the strobes and addresses are known values, never X, in every cycle after reset. The strobes must be free to occur in any cycle, including both at once and back to back. The bench holds reset for three clocks and drives every input on the falling edge, with defined values in every cycle. Its random traffic is aimed at the status words, the command word, both sides of the storage limit and command codes near the reset and shutdown values, so those conditions are reached often.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int SC_ADDR_W      = 12;
    localparam int SC_DATA_W      = 32;
    localparam int SC_STORE_WORDS = 512;
    localparam int SC_CMD_BYTE    = 'hF00;

    localparam logic [31:0] SC_FORCE_MASK = 32'h3000_0000;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_RESET    = 2'd1,
        CMD_SHUTDOWN = 2'd2
    } cmd_e;

    typedef struct packed {
        logic [9:0] idx;
        logic       in_store;
        logic       is_cmd;
        logic       is_status;
    } addr_info_t;

    function automatic logic [31:0] id_reset_value(input int slot);
        case (slot)
            'h40:    return 32'h05F2_0121;
            'h41:    return 32'h0000_0002;
            'h42:    return 32'h05F3_0121;
            'h43:    return 32'h05F4_0121;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic status_index(input logic [9:0] idx);
        return (idx == 10'h040) || (idx == 10'h042) || (idx == 10'h043);
    endfunction

    function automatic cmd_e classify_cmd(input logic [31:0] value);
        if (value == 32'd1 || value == 32'd2) return CMD_RESET;
        if (value == 32'd3)                   return CMD_SHUTDOWN;
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W      = SC_ADDR_W,
    parameter int STORE_WORDS = SC_STORE_WORDS,
    parameter int CMD_BYTE    = SC_CMD_BYTE
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_info_t        info
);
    localparam int IDX_W   = ADDR_W - 2;
    localparam int CMD_IDX = CMD_BYTE / 4;

    logic [IDX_W-1:0] idx;

    assign idx = addr[ADDR_W-1:2];

    always_comb begin
        info           = '0;
        info.idx       = 10'(idx);
        info.in_store  = (int'(idx) < STORE_WORDS);
        info.is_cmd    = (int'(idx) == CMD_IDX);
        info.is_status = status_index(10'(idx));
    end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int DATA_W      = SC_DATA_W,
    parameter int STORE_WORDS = SC_STORE_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [9:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [9:0]        rd_idx,
    output logic [DATA_W-1:0] rd_word
);
    localparam int SLOT_W = $clog2(STORE_WORDS);

    logic [DATA_W-1:0] mem [STORE_WORDS];
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;

    assign wr_slot = wr_idx[SLOT_W-1:0];
    assign rd_slot = rd_idx[SLOT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STORE_WORDS; i++) begin
                mem[i] <= DATA_W'(id_reset_value(i));
            end
        end else if (we) begin
            mem[wr_slot] <= wr_data;
        end
    end

    assign rd_word = mem[rd_slot];
endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
    import sysctl_pkg::*;
#(
    parameter int DATA_W = SC_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_is_cmd,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cmd_word,
    output logic              rst_req,
    output logic              shut_req
);
    cmd_e code;

    assign code = classify_cmd(32'(wr_data));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_word <= '0;
            rst_req  <= 1'b0;
            shut_req <= 1'b0;
        end else begin
            rst_req  <= wr_en && wr_is_cmd && (code == CMD_RESET);
            shut_req <= wr_en && wr_is_cmd && (code == CMD_SHUTDOWN);
            if (wr_en && wr_is_cmd) begin
                cmd_word <= wr_data;
            end
        end
    end

    // R5 / R6: a request only follows a write to the command word
    a_r5_rst_after_cmd_write: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> ($past(wr_en) && $past(wr_is_cmd)));
    a_r6_shut_after_cmd_write: assert property (@(posedge clk) disable iff (rst)
        shut_req |-> ($past(wr_en) && $past(wr_is_cmd)));
    // R6: a shutdown request leaves the stored command word at the shutdown code
    a_r6_shut_word: assert property (@(posedge clk) disable iff (rst)
        shut_req |-> (cmd_word == DATA_W'(3)));
    // R7: the two requests never coincide
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && shut_req));
endmodule

// File: rtl/sysctl_rdpath.sv
module sysctl_rdpath
    import sysctl_pkg::*;
#(
    parameter int DATA_W = SC_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  addr_info_t        info,
    input  logic [DATA_W-1:0] store_word,
    input  logic [DATA_W-1:0] cmd_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] next_word;

    always_comb begin
        if (info.is_cmd) begin
            next_word = cmd_word;
        end else if (info.in_store) begin
            next_word = store_word;
            if (info.is_status) begin
                next_word = store_word | DATA_W'(SC_FORCE_MASK);
            end
        end else begin
            next_word = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= next_word;
        end
    end

    // R9: out-of-window reads return zero
    a_r9_outside_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && !$past(info.in_store) && !$past(info.is_cmd)) |-> (rd_data == '0));
    // R4: status reads always show bits 29:28 set
    a_r4_status_bits: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(info.is_status)) |-> (rd_data[29:28] == 2'b11));
    // R10: data holds without a strobe
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int ADDR_W      = SC_ADDR_W,
    parameter int DATA_W      = SC_DATA_W,
    parameter int STORE_WORDS = SC_STORE_WORDS,
    parameter int CMD_BYTE    = SC_CMD_BYTE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rst_req,
    output logic              shut_req
);
    addr_info_t        wr_info;
    addr_info_t        rd_info;
    logic              store_we;
    logic [DATA_W-1:0] store_word;
    logic [DATA_W-1:0] cmd_word;

    sysctl_decode #(.ADDR_W(ADDR_W), .STORE_WORDS(STORE_WORDS), .CMD_BYTE(CMD_BYTE))
        u_wr_dec (.addr(wr_addr), .info(wr_info));

    sysctl_decode #(.ADDR_W(ADDR_W), .STORE_WORDS(STORE_WORDS), .CMD_BYTE(CMD_BYTE))
        u_rd_dec (.addr(rd_addr), .info(rd_info));

    assign store_we = wr_en && wr_info.in_store;

    sysctl_regfile #(.DATA_W(DATA_W), .STORE_WORDS(STORE_WORDS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (store_we),
        .wr_idx  (wr_info.idx),
        .wr_data (wr_data),
        .rd_idx  (rd_info.idx),
        .rd_word (store_word)
    );

    sysctl_cmd #(.DATA_W(DATA_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_is_cmd (wr_info.is_cmd),
        .wr_data   (wr_data),
        .cmd_word  (cmd_word),
        .rst_req   (rst_req),
        .shut_req  (shut_req)
    );

    sysctl_rdpath #(.DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .info       (rd_info),
        .store_word (store_word),
        .cmd_word   (cmd_word),
        .rd_data    (rd_data)
    );

    // R8: command word reads return the last command written
    a_r8_cmd_readback: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(rd_info.is_cmd) && !$past(wr_en)) |-> (rd_data == $past(cmd_word)));
endmodule

// File: tb/sysctl_regs_bench.sv
`timescale 1ns/1ps
module sysctl_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        rst_req;
    logic        shut_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] model [512];
    logic [31:0] m_cmd;
    logic [31:0] last_rd;

    always #2 clk = ~clk;

    sysctl_regs u_sysctl_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rst_req(rst_req), .shut_req(shut_req)
    );

    function automatic logic [31:0] ident(input int i);
        case (i)
            'h40: return 32'h05F2_0121;
            'h41: return 32'h0000_0002;
            'h42: return 32'h05F3_0121;
            'h43: return 32'h05F4_0121;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int i = int'(a[11:2]);
        logic [31:0] v;
        if (i == 'h3C0) return m_cmd;
        if (i >= 512) return 32'h0;
        v = model[i];
        if (i == 'h40 || i == 'h42 || i == 'h43) v = v | 32'h3000_0000;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit we, input logic [11:0] wa, input logic [31:0] wd,
                        input bit re, input logic [11:0] ra, input string rtag);
        logic [31:0] erd;
        bit cmdw, er, es;
        erd = re ? exp_read(ra) : last_rd;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        @(posedge clk);
        @(negedge clk);
        cmdw = we && (wa[11:2] == 10'h3C0);
        er = cmdw && (wd == 32'd1 || wd == 32'd2);
        es = cmdw && (wd == 32'd3);
        chk(rtag, rd_data, erd);
        chk(er ? "R5 rst_req" : "R7 rst_req", {31'b0, rst_req}, {31'b0, er});
        chk(es ? "R6 shut_req" : "R7 shut_req", {31'b0, shut_req}, {31'b0, es});
        last_rd = erd;
        if (we) begin
            if (int'(wa[11:2]) < 512) model[int'(wa[11:2])] = wd;
            if (cmdw) m_cmd = wd;
        end
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] picks [10];
        for (int i = 0; i < 512; i++) model[i] = ident(i);
        m_cmd = '0;
        last_rd = '0;
        picks = '{12'h000, 12'h004, 12'h100, 12'h104, 12'h108, 12'h10C,
                  12'hF00, 12'h7FC, 12'h800, 12'hFFC};
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 rd_data reset", rd_data, 32'h0);
        chk("R1 rst_req reset", {31'b0, rst_req}, 32'h0);
        chk("R1 shut_req reset", {31'b0, shut_req}, 32'h0);

        step(0, 0, 0, 1, 12'h100, "R1 id 0x40");
        chk("R1 id 0x40 value", rd_data, 32'h35F2_0121);
        step(0, 0, 0, 1, 12'h104, "R1 id 0x41");
        step(0, 0, 0, 1, 12'h108, "R1 id 0x42");
        step(0, 0, 0, 1, 12'h10C, "R1 id 0x43");
        step(0, 0, 0, 1, 12'h000, "R1 zero word");
        step(0, 0, 0, 1, 12'hF00, "R1 cmd word");

        step(1, 12'h004, 32'hA5A5_5A5A, 0, 0, "R10 hold");
        step(0, 0, 0, 1, 12'h004, "R2 readback");
        step(1, 12'h010, 32'h1234_5678, 1, 12'h010, "R3 old value");
        step(0, 0, 0, 1, 12'h010, "R3 new value");

        step(1, 12'h100, 32'h0, 0, 0, "R10 hold");
        step(0, 0, 0, 1, 12'h100, "R4 forced bits");
        step(1, 12'h108, 32'h0000_00FF, 0, 0, "R10 hold");
        step(0, 0, 0, 1, 12'h108, "R4 forced bits keep rest");
        step(1, 12'h104, 32'h0, 1, 12'h104, "R4 unforced old");
        step(0, 0, 0, 1, 12'h104, "R4 unforced word");

        step(1, 12'hF00, 32'd1, 0, 0, "R5 code 1");
        step(0, 0, 0, 0, 0, "R5 pulse ends");
        step(1, 12'hF00, 32'd2, 0, 0, "R5 code 2");
        step(1, 12'hF00, 32'd3, 0, 0, "R6 code 3");
        step(0, 0, 0, 1, 12'hF00, "R8 cmd stored 3");
        step(1, 12'hF00, 32'd0, 0, 0, "R7 code 0");
        step(1, 12'hF00, 32'd4, 0, 0, "R7 code 4");
        step(1, 12'hF00, 32'hFFFF_FFFF, 0, 0, "R7 code all ones");
        step(1, 12'hF04, 32'd1, 0, 0, "R7 other offset");
        step(0, 0, 0, 1, 12'hF00, "R8 cmd stored");

        step(1, 12'h800, 32'hDEAD_BEEF, 0, 0, "R10 hold");
        step(0, 0, 0, 1, 12'h800, "R9 read outside");
        step(0, 0, 0, 1, 12'h000, "R9 no alias");
        step(0, 0, 0, 1, 12'hFFC, "R9 top word");
        step(0, 0, 0, 0, 0, "R10 idle hold");

        step(1, 12'h023, 32'hCAFE_0001, 0, 0, "R10 hold");
        step(0, 0, 0, 1, 12'h020, "R11 low bits ignored");
        step(0, 0, 0, 1, 12'h022, "R11 low bits ignored read");

        for (int n = 0; n < 3000; n++) begin
            bit we, re;
            logic [11:0] wa, ra;
            logic [31:0] wd;
            we = ($urandom % 2) == 0;
            re = ($urandom % 4) != 0;
            wa = ($urandom % 2) ? picks[$urandom % 10] : 12'($urandom);
            ra = ($urandom % 3) == 0 ? wa : (($urandom % 2) ? picks[$urandom % 10] : 12'($urandom));
            wd = ($urandom % 3) == 0 ? 32'($urandom % 5) : $urandom;
            step(we, wa, wd, re, ra, "R2 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule